// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable, device-side model of a 4096-bit serial EEPROM with a three-wire synchronous interface: a select line, a serial clock and a serial data input, plus a data output with a separate output-enable. All three inputs are first passed through a synchroniser into the system clock domain. The serial clock's rising edges are then detected there, so the model runs entirely on `clk`. A host controller in a testbench, or an emulation platform, talks to it exactly as it would talk to a real memory part.

The array holds either 256 words of 16 bits or 512 words of 8 bits. The organisation is chosen by a pin that is sampled during reset. An instruction is a start bit, a two-bit operation code and an address, and write-type instructions add a data word. The model covers these functions:

- Single-word read, which continues as a sequential read while the select line stays high.
- Single-word write and single-word erase.
- Whole-array erase and whole-array write.
- Enabling and disabling modification of the array.

Program and erase cycles are timed internally in system clocks after the select line falls. While a cycle runs, its progress is shown on the data output.

The serial pins form a fixed bit-level protocol with no flow control. The host sets the pace by the serial clock alone, so these pins carry no valid/ready pair. Every other pin is a plain level.

Top module: `serial_eeprom_model`

## Requirements
- R1: `org_i` is sampled only while `rst_n` is low; 1 selects 256×16 with 8 address bits, 0 selects 512×8 with 9 address bits. The array contents are not altered by reset. Word `a` in the 16-bit layout occupies byte `2a` (its upper 8 bits) and byte `2a+1` (its lower 8 bits) of the 8-bit layout.
- R2: An instruction is a 1 start bit, then a 2-bit code, then the address, all MSB first. The codes are: 10 read, 01 write one word (followed by a data word, MSB first), 11 erase one word. Code 00 is qualified by the two top address bits: 11 enables modification, 00 disables it, 10 erases all, 01 writes all (followed by a data word).
- R3: When the last read address bit is taken on a rising serial clock edge, `do_oe_o` goes high and `do_o` shows a single 0. Each following rising edge presents the next bit of the addressed word, MSB first.
- R4: While select stays high, the read continues with the next address with no extra 0 bit. After the last address (255 or 511) it continues at address 0.
- R5: After reset, modification is disabled. When disabled, write, erase, erase-all and write-all leave the array unchanged and start no cycle, so no status appears on the next select. The enable persists until the disable instruction or a reset.
- R6: Reads return the array contents whether modification is enabled or disabled.
- R7: A modifying instruction starts its cycle when select falls after the instruction is complete. The cycle lasts `PROG_CYCLES` system clocks and needs no serial clock edges.
- R8: Erased locations read all ones. A write replaces the old word with no prior erase. Erase-all sets every location to all ones, and write-all stores the data word in every location.
- R9: After a cycle has started, raising select drives `do_oe_o`=1 with `do_o`=0 while busy and `do_o`=1 when ready. A 1 clocked into the data input while status is shown sets `do_oe_o` to 0, and that 1 is not a start bit.
- R10: `do_oe_o` is 0 during reset, whenever select is low, and at all times other than read data and status.
- R11: Zeros clocked in before the start bit are ignored. Dropping select before an instruction is complete abandons it with no effect on the array and no status.
- R12: While a cycle is busy, all clocked-in bits are ignored and cannot start or change an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all model state runs on it |
| rst_n | input | 1 | Active-low asynchronous reset; samples `org_i` |
| cs_i | input | 1 | Chip select, active high, asynchronous to `clk` |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host, taken on rising `sk_i` |
| org_i | input | 1 | Organisation select: 1 = 16-bit words, 0 = 8-bit words |
| do_o | output | 1 | Serial data / status output; 0 when not enabled |
| do_oe_o | output | 1 | Output enable for `do_o`; 0 means high impedance |

## Verification
The assertions assume that `cs_i`, `sk_i` and `di_i` are held stable for at least a few system clocks around each serial clock edge, so that the synchroniser delivers them as one aligned set. The bench therefore changes the pins only on falling system clock edges. It holds each serial clock phase for four system clocks and changes the data input only while the serial clock is low. It also keeps instructions issued during a busy cycle short enough to end before that cycle finishes. Random operations, addresses and data are drawn from a fixed seed and mixed with directed cases for the wrap point, disabled writes, aborts, leading zeros and both organisations.

// File: rtl/seep_pkg.sv
package seep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } seep_state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WRITE,
    OP_ERASE,
    OP_ERASE_ALL,
    OP_WRITE_ALL
  } seep_op_e;

  localparam logic [1:0] CODE_READ  = 2'b10;
  localparam logic [1:0] CODE_WRITE = 2'b01;
  localparam logic [1:0] CODE_ERASE = 2'b11;
  localparam logic [1:0] CODE_EXT   = 2'b00;

  localparam logic [1:0] SUB_ENABLE    = 2'b11;
  localparam logic [1:0] SUB_DISABLE   = 2'b00;
  localparam logic [1:0] SUB_ERASE_ALL = 2'b10;
  localparam logic [1:0] SUB_WRITE_ALL = 2'b01;

endpackage

// File: rtl/seep_sync.sv
module seep_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/seep_prog_timer.sv
module seep_prog_timer #(
  parameter int CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      remain_q <= '0;
    end else if (start_i && !busy_o) begin
      busy_o   <= 1'b1;
      remain_q <= CNT_W'(CYCLES - 1);
    end else if (busy_o) begin
      if (remain_q == '0) busy_o <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end
  end

  assign done_o = busy_o && (remain_q == '0);

endmodule

// File: rtl/seep_array.sv
module seep_array
  import seep_pkg::*;
#(
  parameter int BYTES  = 512,
  parameter int WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      org16_i,
  input  logic                      commit_i,
  input  seep_op_e                  op_i,
  input  logic [$clog2(BYTES)-1:0]  addr_i,
  input  logic [WORD_W-1:0]         data_i,
  output logic [WORD_W-1:0]         rd_word_o
);

  localparam int BAW    = $clog2(BYTES);
  localparam int BYTE_W = WORD_W / 2;

  logic [BYTE_W-1:0] mem [BYTES];
  logic [BAW-1:0]    hi_idx, lo_idx;

  assign hi_idx = {addr_i[BAW-2:0], 1'b0};
  assign lo_idx = {addr_i[BAW-2:0], 1'b1};

  always_ff @(posedge clk) begin
    if (commit_i) begin
      case (op_i)
        OP_WRITE: begin
          if (org16_i) begin
            mem[hi_idx] <= data_i[WORD_W-1:BYTE_W];
            mem[lo_idx] <= data_i[BYTE_W-1:0];
          end else begin
            mem[addr_i] <= data_i[BYTE_W-1:0];
          end
        end
        OP_ERASE: begin
          if (org16_i) begin
            mem[hi_idx] <= '1;
            mem[lo_idx] <= '1;
          end else begin
            mem[addr_i] <= '1;
          end
        end
        OP_ERASE_ALL: begin
          for (int i = 0; i < BYTES; i++) mem[i] <= '1;
        end
        OP_WRITE_ALL: begin
          for (int i = 0; i < BYTES; i++) begin
            if (org16_i && !i[0]) mem[i] <= data_i[WORD_W-1:BYTE_W];
            else                  mem[i] <= data_i[BYTE_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (org16_i) rd_word_o = {mem[hi_idx], mem[lo_idx]};
    else         rd_word_o = {{BYTE_W{1'b0}}, mem[addr_i]};
  end

endmodule

// File: rtl/serial_eeprom_model.sv
module serial_eeprom_model
  import seep_pkg::*;
#(
  parameter int MEM_BITS    = 4096,
  parameter int NARROW_W    = 8,
  parameter int PROG_CYCLES = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);

  localparam int WIDE_W    = 2 * NARROW_W;
  localparam int BYTES     = MEM_BITS / NARROW_W;
  localparam int NAW       = $clog2(BYTES);
  localparam int WAW       = NAW - 1;
  localparam int SR_W      = NAW + 2;
  localparam int CW        = $clog2(WIDE_W + SR_W) + 1;
  localparam int IW        = $clog2(WIDE_W);

  // synchronised pins
  logic [2:0] pins_s;
  logic cs_s, sk_s, di_s, sk_prev, sk_rise;

  seep_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cs_i, sk_i, di_i}),
    .q_o   (pins_s)
  );

  assign {cs_s, sk_s, di_s} = pins_s;
  assign sk_rise = sk_s && !sk_prev;

  // control state
  seep_state_e     state;
  seep_op_e        op_q;
  logic            org16_q, wen_q, status_q, out_bit;
  logic [CW-1:0]   bit_cnt, rd_cnt;
  logic [SR_W-1:0] sreg, sh_nx;
  logic [NAW-1:0]  addr_q, addr_nx, dec_addr;
  logic [WIDE_W-1:0] data_q, rd_word;
  logic [1:0]      dec_code, dec_sub;
  logic [CW-1:0]   cmd_last, data_last;
  logic [IW-1:0]   rd_idx;
  logic            busy, commit, prog_start, in_read, show_status;

  assign sh_nx     = {sreg[SR_W-2:0], di_s};
  assign dec_code  = org16_q ? sh_nx[WAW+1 -: 2] : sh_nx[NAW+1 -: 2];
  assign dec_sub   = org16_q ? sh_nx[WAW-1 -: 2] : sh_nx[NAW-1 -: 2];
  assign dec_addr  = org16_q ? NAW'(sh_nx[WAW-1:0]) : sh_nx[NAW-1:0];
  assign cmd_last  = org16_q ? CW'(WAW + 1) : CW'(NAW + 1);
  assign data_last = org16_q ? CW'(WIDE_W - 1) : CW'(NARROW_W - 1);
  assign rd_idx    = IW'(data_last - rd_cnt);
  assign addr_nx   = org16_q ? {1'b0, addr_q[WAW-1:0] + 1'b1} : addr_q + 1'b1;

  assign in_read     = (state == ST_READ);
  assign prog_start  = !cs_s && (state == ST_HOLD) && (op_q != OP_NONE);
  assign show_status = status_q && (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= OP_NONE;
      org16_q  <= org_i;
      wen_q    <= 1'b0;
      status_q <= 1'b0;
      out_bit  <= 1'b0;
      bit_cnt  <= '0;
      rd_cnt   <= '0;
      sreg     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      sk_prev  <= 1'b0;
    end else begin
      sk_prev <= sk_s;

      if (prog_start)
        status_q <= 1'b1;
      else if (show_status && cs_s && sk_rise && di_s)
        status_q <= 1'b0;

      if (!cs_s) begin
        state <= ST_IDLE;
      end else if (sk_rise) begin
        case (state)
          ST_IDLE: begin
            if (di_s && !status_q && !busy) begin
              state   <= ST_CMD;
              bit_cnt <= '0;
              sreg    <= '0;
            end
          end
          ST_CMD: begin
            sreg <= sh_nx;
            if (bit_cnt == cmd_last) begin
              bit_cnt <= '0;
              addr_q  <= dec_addr;
              data_q  <= '0;
              case (dec_code)
                CODE_READ: begin
                  state   <= ST_READ;
                  rd_cnt  <= '0;
                  out_bit <= 1'b0;
                end
                CODE_WRITE: begin
                  state <= ST_DATA;
                  op_q  <= wen_q ? OP_WRITE : OP_NONE;
                end
                CODE_ERASE: begin
                  state <= ST_HOLD;
                  op_q  <= wen_q ? OP_ERASE : OP_NONE;
                end
                default: begin
                  case (dec_sub)
                    SUB_ENABLE: begin
                      state <= ST_HOLD;
                      op_q  <= OP_NONE;
                      wen_q <= 1'b1;
                    end
                    SUB_DISABLE: begin
                      state <= ST_HOLD;
                      op_q  <= OP_NONE;
                      wen_q <= 1'b0;
                    end
                    SUB_ERASE_ALL: begin
                      state <= ST_HOLD;
                      op_q  <= wen_q ? OP_ERASE_ALL : OP_NONE;
                    end
                    default: begin
                      state <= ST_DATA;
                      op_q  <= wen_q ? OP_WRITE_ALL : OP_NONE;
                    end
                  endcase
                end
              endcase
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_DATA: begin
            data_q <= {data_q[WIDE_W-2:0], di_s};
            if (bit_cnt == data_last) state <= ST_HOLD;
            else                      bit_cnt <= bit_cnt + 1'b1;
          end
          ST_READ: begin
            out_bit <= rd_word[rd_idx];
            if (rd_cnt == data_last) begin
              rd_cnt <= '0;
              addr_q <= addr_nx;
            end else begin
              rd_cnt <= rd_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  seep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (prog_start),
    .busy_o  (busy),
    .done_o  (commit)
  );

  seep_array #(.BYTES(BYTES), .WORD_W(WIDE_W)) u_array (
    .clk       (clk),
    .org16_i   (org16_q),
    .commit_i  (commit),
    .op_i      (op_q),
    .addr_i    (addr_q),
    .data_i    (data_q),
    .rd_word_o (rd_word)
  );

  assign do_oe_o = cs_s && (in_read || show_status);
  assign do_o    = do_oe_o && (in_read ? out_bit : !busy);

endmodule

// File: rtl/seep_checker.sv
module seep_checker #(
  parameter int PROG_CYCLES = 1000000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_i,
  input logic do_o,
  input logic do_oe_o,
  input logic busy,
  input logic prog_start,
  input logic wen_q,
  input logic in_read,
  input logic sk_rise
);

  logic [2:0]  cs_low_cnt;
  logic [31:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_low_cnt <= '0;
      busy_cnt   <= '0;
    end else begin
      if (cs_i)                 cs_low_cnt <= '0;
      else if (cs_low_cnt != 3'd7) cs_low_cnt <= cs_low_cnt + 1'b1;
      if (busy) busy_cnt <= busy_cnt + 1'b1;
      else      busy_cnt <= '0;
    end
  end

  // output stays released once select has been low for a while
  assert_quiet_when_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low_cnt >= 3'd4) |-> !do_oe_o);

  // the timed cycle never outlasts its parameter
  assert_cycle_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < 32'(PROG_CYCLES)));

  // a cycle can only begin while modification is enabled
  assert_start_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q));

  // the enable latch only moves on a serial clock edge
  assert_enable_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen_q) |-> $past(sk_rise));

  // first bit of a read is the leading zero
  assert_read_lead_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_read) |-> (do_oe_o && !do_o));

  // status reads zero during a cycle
  assert_busy_status_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_oe_o && busy) |-> !do_o);

  // no new cycle is requested while one runs
  assert_no_start_when_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !busy);

endmodule

bind serial_eeprom_model seep_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_i       (cs_i),
  .do_o       (do_o),
  .do_oe_o    (do_oe_o),
  .busy       (busy),
  .prog_start (prog_start),
  .wen_q      (wen_q),
  .in_read    (in_read),
  .sk_rise    (sk_rise)
);

// File: tb/serial_eeprom_model_test.sv
`timescale 1ns/1ps
module serial_eeprom_model_test;

  localparam int PROG = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_o, do_oe_o;
  logic last_do, last_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit org16_b = 1'b1;
  logic [7:0] exp_mem [512];

  always #2.5 clk = ~clk;

  serial_eeprom_model #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .org_i(org),
    .do_o(do_o), .do_oe_o(do_oe_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int aw();
    return org16_b ? 8 : 9;
  endfunction
  function automatic int ww();
    return org16_b ? 16 : 8;
  endfunction
  function automatic int nwords();
    return org16_b ? 256 : 512;
  endfunction

  function automatic logic [15:0] exp_word(input int a);
    if (org16_b) return {exp_mem[2*a], exp_mem[2*a+1]};
    return {8'h00, exp_mem[a]};
  endfunction

  task automatic put_word(input int a, input logic [15:0] d);
    if (org16_b) begin
      exp_mem[2*a] = d[15:8];
      exp_mem[2*a+1] = d[7:0];
    end else exp_mem[a] = d[7:0];
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    di = b; sk = 1'b0; wait_clks(4);
    sk = 1'b1; wait_clks(4);
    last_do = do_o; last_oe = do_oe_o;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask

  task automatic cs_up();
    sk = 1'b0; cs = 1'b1; wait_clks(4);
  endtask
  task automatic cs_down();
    sk = 1'b0; di = 1'b0; cs = 1'b0; wait_clks(4);
  endtask

  task automatic do_reset(input logic o);
    cs = 1'b0; sk = 1'b0; di = 1'b0; org = o; rst_n = 1'b0;
    wait_clks(5);
    chk("R10 oe in reset", {31'd0, do_oe_o}, 32'd0);
    rst_n = 1'b1; org16_b = o;
    wait_clks(3);
    org = ~o;
  endtask

  // cycle already requested; select has not yet dropped
  task automatic finish_cycle(input string req);
    int n;
    cs_down();
    cs_up();
    chk({req, " R9 busy status"}, {30'd0, do_oe_o, do_o}, 32'd2);
    n = 8;
    while (do_o !== 1'b1 && n < PROG + 100) begin
      @(negedge clk); n++;
    end
    chk({req, " R7 cycle length"}, 32'(n >= PROG && n <= PROG + 12), 32'd1);
    chk({req, " R9 ready status"}, {30'd0, do_oe_o, do_o}, 32'd3);
    sk_bit(1'b1);
    chk({req, " R9 release by 1"}, {31'd0, last_oe}, 32'd0);
    cs_down();
  endtask

  task automatic no_status(input string req);
    cs_down();
    cs_up();
    chk({req, " no status"}, {31'd0, do_oe_o}, 32'd0);
    cs_down();
  endtask

  task automatic ext_cmd(input logic [1:0] sub);
    cs_up(); sk_bit(1'b1); send_bits(0, 2);
    send_bits({30'd0, sub} << (aw() - 2), aw());
  endtask

  task automatic set_enable(input logic en);
    ext_cmd(en ? 2'b11 : 2'b00);
    cs_down();
  endtask

  // R2 write with code 01
  task automatic write_word(input int a, input logic [15:0] d, input bit en);
    cs_up(); sk_bit(1'b1); send_bits(2'b01, 2); send_bits(a, aw()); send_bits(d, ww());
    if (en) begin finish_cycle("R8 write"); put_word(a, d); end
    else no_status("R5 write disabled");
  endtask

  task automatic erase_word(input int a, input bit en);
    cs_up(); sk_bit(1'b1); send_bits(2'b11, 2); send_bits(a, aw());
    if (en) begin finish_cycle("R8 erase"); put_word(a, 16'hFFFF); end
    else no_status("R5 erase disabled");
  endtask

  task automatic erase_all(input bit en);
    ext_cmd(2'b10);
    if (en) begin
      finish_cycle("R8 erase all");
      for (int i = 0; i < 512; i++) exp_mem[i] = 8'hFF;
    end else no_status("R5 erase all disabled");
  endtask

  task automatic write_all(input logic [15:0] d, input bit en);
    ext_cmd(2'b01); send_bits(d, ww());
    if (en) begin
      finish_cycle("R8 write all");
      for (int i = 0; i < nwords(); i++) put_word(i, d);
    end else no_status("R5 write all disabled");
  endtask

  task automatic read_seq(input int a, input int n, input int lead, input string req);
    int cur;
    logic [15:0] w;
    cs_up();
    for (int i = 0; i < lead; i++) sk_bit(1'b0);
    sk_bit(1'b1); send_bits(2'b10, 2); send_bits(a, aw());
    chk({req, " R3 dummy zero"}, {30'd0, last_oe, last_do}, 32'd2);
    cur = a;
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int b = 0; b < ww(); b++) begin
        sk_bit(1'b0);
        w = {w[14:0], last_do};
      end
      chk({req, " R3 R4 read word"}, {16'd0, w}, {16'd0, exp_word(cur)});
      cur = (cur + 1) % nwords();
    end
    cs_down();
    chk({req, " R10 released"}, {31'd0, do_oe_o}, 32'd0);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    report();
    $finish;
  end

  initial begin
    int a, b, r;
    logic [15:0] d;
    void'($urandom(32'h5EED1234));
    do_reset(1'b1);
    chk("R10 idle oe", {31'd0, do_oe_o}, 32'd0);

    // R5 disabled out of reset
    write_word(3, 16'h1234, 1'b0);
    erase_all(1'b0);
    set_enable(1'b1);
    erase_all(1'b1);
    read_seq(0, 2, 0, "R8 after erase all");
    set_enable(1'b0);
    write_word(5, 16'h1234, 1'b0);
    write_all(16'h0000, 1'b0);
    read_seq(5, 1, 0, "R6 read while disabled");

    set_enable(1'b1);
    write_word(5, 16'hA55A, 1'b1);
    write_word(5, 16'h0F0F, 1'b1);
    read_seq(5, 1, 0, "R8 overwrite");
    erase_word(5, 1'b1);
    read_seq(5, 1, 0, "R8 erased word");
    write_word(254, 16'h1111, 1'b1);
    write_word(255, 16'h2222, 1'b1);
    write_word(0, 16'h3333, 1'b1);
    read_seq(254, 4, 0, "R4 wrap x16");
    read_seq(254, 1, 3, "R11 leading zeros");

    // R11 abort mid data
    cs_up(); sk_bit(1'b1); send_bits(2'b01, 2); send_bits(254, 8); send_bits(8'h00, 8);
    no_status("R11 abort");
    read_seq(254, 1, 0, "R11 abort no change");

    // R12 bits ignored while busy
    cs_up(); sk_bit(1'b1); send_bits(2'b01, 2); send_bits(10, 8); send_bits(16'hBEEF, 16);
    cs_down(); cs_up();
    chk("R12 busy seen", {30'd0, do_oe_o, do_o}, 32'd2);
    sk_bit(1'b1);
    chk("R9 R12 released while busy", {31'd0, last_oe}, 32'd0);
    sk_bit(1'b1); send_bits(2'b01, 2); send_bits(11, 8); send_bits(16'hDEAD, 16);
    cs_down();
    wait_clks(PROG + 20);
    put_word(10, 16'hBEEF);
    no_status("R12 ignored instr");
    read_seq(10, 2, 0, "R12 busy ignore");

    write_all(16'hC3A5, 1'b1);
    read_seq(100, 3, 0, "R8 write all");

    for (int it = 0; it < 30; it++) begin
      r = $urandom % 4; a = $urandom % 256; d = 16'($urandom);
      case (r)
        0: write_word(a, d, 1'b1);
        1: erase_word(a, 1'b1);
        2: read_seq(a, 1 + ($urandom % 3), 0, "R3 random read");
        default: begin write_word(a, d, 1'b1); read_seq(a, 1, 0, "R2 random write"); end
      endcase
    end

    // R1 switch layout; contents survive, enable cleared
    do_reset(1'b0);
    read_seq(20, 2, 0, "R1 byte view");
    write_word(40, 16'h0077, 1'b0);
    read_seq(40, 1, 0, "R5 disabled after reset");
    set_enable(1'b1);
    write_word(511, 16'h005A, 1'b1);
    write_word(0, 16'h00C3, 1'b1);
    read_seq(510, 4, 0, "R4 wrap x8");
    for (int it = 0; it < 10; it++) begin
      b = $urandom % 512; d = 16'($urandom % 256);
      write_word(b, d, 1'b1);
      read_seq(b, 1, 0, "R1 x8 random");
    end
    write_all(16'h003C, 1'b1);
    read_seq(300, 2, 0, "R8 write all x8");

    do_reset(1'b1);
    read_seq(7, 2, 0, "R1 word view");

    report();
    $finish;
  end

endmodule